// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port, 36-bit wide synchronous memory, built as four 9-bit bytes, that takes a new command on any clock edge. The data for each command moves exactly two edges after the command: read data appears two edges later, and write data is captured two edges later. Because reads and writes share that fixed latency, they can alternate on consecutive cycles with no idle slot between them. An on-chip counter lets one loaded address supply a run of beats. The beats follow either a linear or an interleaved order within a block of four words.

The command port has the following inputs:
- an address
- a load/advance strobe
- a read/write select
- an active-low clock enable, which freezes everything when high
- three chip selects of mixed polarity
- four active-low byte write strobes

Data-in and data-out are separate buses. A drive flag marks when data-out is valid and would be driven. An asynchronous output enable gates that flag.

Top module: `zbt_sram`

## Requirements
- R1: After reset is released, rdata_en_o stays low until a read command has travelled through the two-stage pipeline.
- R2: A read loaded on edge k (load strobe low, clock enable low, chip selected, rw_i=1) puts the addressed word on rdata_o with rdata_en_o high after edge k+2, when oe_n_i is low.
- R3: A write loaded on edge k (rw_i=0) captures wdata_i on edge k+2. Byte b (bits 9b+8..9b) is written only when bw_n_i[b] was low on the command edge. A write slot never raises rdata_en_o.
- R4: bw_n_i has no effect on read commands.
- R5: Reads and writes may alternate on consecutive edges. A read that follows a write to the same address returns the newly written bytes merged over the older ones, including when the write immediately precedes the read.
- R6: An edge with cke_n_i high is ignored. No command is taken, memory does not change, and rdata_o and the drive state hold.
- R7: With the load strobe low, the chip is deselected when cs1_n_i is high, cs2_i is low or cs3_n_i is high. That edge issues no access, and the drive flag goes low two edges later.
- R8: With the load strobe high, addr_i and rw_i are ignored. The next beat keeps the burst's access type and its upper address bits. With burst_ilv_i=0 the low two address bits step as base+n modulo 4.
- R9: With burst_ilv_i=1, the low two address bits of beat n are the base XOR n.
- R10: A deselect loaded with the strobe low ends a burst. Later advance edges issue no access.
- R11: While oe_n_i is high, rdata_en_o is low. This does not disturb the pipeline.
- R12: An advance edge with no burst active, for example straight after reset, issues no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| cke_n_i | input | 1 | Clock enable, active low |
| adv_ld_n_i | input | 1 | Low: load a new command; high: advance the burst |
| rw_i | input | 1 | 1 = read, 0 = write (used on load edges) |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_n_i | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Word address |
| bw_n_i | input | BYTES | Byte write strobes, active low |
| burst_ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| wdata_i | input | BYTES*BYTE_W | Write data, sampled two edges after its command |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | BYTES*BYTE_W | Read data |
| rdata_en_o | output | 1 | Read data valid and driven |

## Verification
Several properties are checked on every edge by the assertions:
- the drive flag rises only from a read in the last stage, and a write slot lowers it;
- a frozen edge leaves the read data untouched;
- a loaded deselect followed by two live edges leaves the bus undriven;
- an advance beat keeps the burst's type and upper address, or issues nothing when no burst is active.

The returned data values can only be shown by the bench's scenarios, which compare the block against a behavioural model on every clock. These values cover byte-masked merging and forwarding from a write one slot ahead, both burst orders with wrap, bursts cut short by a deselect, freezes in mid-traffic and output-enable gating.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int unsigned ZBT_BYTES   = 4;
  localparam int unsigned ZBT_BYTE_W  = 9;
  localparam int unsigned ZBT_BURST_W = 2;
  localparam int unsigned ZBT_ADDR_W  = 10;
endpackage

// File: rtl/zbt_cmd.sv
// Command decode, burst counter and stage-1 register.
module zbt_cmd
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W  = ZBT_ADDR_W,
  parameter int unsigned BYTES   = ZBT_BYTES,
  parameter int unsigned BURST_W = ZBT_BURST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_n_i,
  input  logic              rd_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTES-1:0]  bw_n_i,
  input  logic              ilv_i,
  output logic              s1_vld_o,
  output logic              s1_rd_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic [BYTES-1:0]  s1_be_o
);
  localparam int unsigned UP_W = ADDR_W - BURST_W;

  logic               act_q;
  logic               rd_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nxt, beat_lo;
  logic               cmd_vld, cmd_rd;
  logic [ADDR_W-1:0]  cmd_addr;

  assign cnt_nxt = cnt_q + 1'b1;

  generate
    if (BURST_W > 0) begin : g_order
      assign beat_lo = ilv_i ? (base_q[BURST_W-1:0] ^ cnt_nxt)
                             : (base_q[BURST_W-1:0] + cnt_nxt);
    end
  endgenerate

  always_comb begin
    if (!ld_n_i) begin
      cmd_vld  = sel_i;
      cmd_rd   = rd_i;
      cmd_addr = addr_i;
    end else begin
      cmd_vld  = act_q;
      cmd_rd   = rd_q;
      cmd_addr = {base_q[ADDR_W-1 -: UP_W], beat_lo};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (!ld_n_i) begin
        act_q  <= sel_i;
        rd_q   <= rd_i;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q  <= cnt_nxt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o  <= 1'b0;
      s1_rd_o   <= 1'b0;
      s1_addr_o <= '0;
      s1_be_o   <= '0;
    end else if (en_i) begin
      s1_vld_o  <= cmd_vld;
      s1_rd_o   <= cmd_rd;
      s1_addr_o <= cmd_addr;
      s1_be_o   <= cmd_rd ? '0 : ~bw_n_i;
    end
  end

  AST_ADV_KEEPS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_n_i && s1_vld_o) |=> (s1_vld_o && (s1_rd_o == $past(s1_rd_o)) &&
      (s1_addr_o[ADDR_W-1 -: UP_W] == $past(s1_addr_o[ADDR_W-1 -: UP_W])))); // R8
  AST_ADV_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_n_i && !s1_vld_o) |=> !s1_vld_o); // R12
endmodule

// File: rtl/zbt_stage.sv
// Generic enabled pipeline register with reset.
module zbt_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/zbt_ram.sv
// Byte-writable array, registered read port.
module zbt_ram
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = ZBT_ADDR_W,
  parameter int unsigned BYTES  = ZBT_BYTES,
  parameter int unsigned BYTE_W = ZBT_BYTE_W
) (
  input  logic                    clk_i,
  input  logic                    en_i,
  input  logic [BYTES-1:0]        we_be_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = BYTES * BYTE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      for (int b = 0; b < BYTES; b++) begin
        if (we_be_i[b]) mem_q[waddr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/zbt_rd_path.sv
// Write-to-read forwarding and output register.
module zbt_rd_path
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W = ZBT_ADDR_W,
  parameter int unsigned BYTES  = ZBT_BYTES,
  parameter int unsigned BYTE_W = ZBT_BYTE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    s1_vld_i,
  input  logic                    s1_rd_i,
  input  logic [ADDR_W-1:0]       s1_addr_i,
  input  logic                    s2_vld_i,
  input  logic                    s2_rd_i,
  input  logic [ADDR_W-1:0]       s2_addr_i,
  input  logic [BYTES-1:0]        s2_be_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic [BYTES*BYTE_W-1:0] ram_q_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    drv_o
);
  localparam int unsigned WORD_W = BYTES * BYTE_W;

  logic              hit;
  logic [BYTES-1:0]  fwd_be_q;
  logic [WORD_W-1:0] fwd_d_q, merged;

  // write committing now is one slot older than the read now sampling the array
  assign hit = s1_vld_i && s1_rd_i && s2_vld_i && !s2_rd_i && (s1_addr_i == s2_addr_i);

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
      assign merged[b*BYTE_W +: BYTE_W] = fwd_be_q[b] ? fwd_d_q[b*BYTE_W +: BYTE_W]
                                                      : ram_q_i[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_be_q <= '0;
      fwd_d_q  <= '0;
    end else if (en_i && s1_vld_i && s1_rd_i) begin
      fwd_be_q <= hit ? s2_be_i : '0;
      fwd_d_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_o   <= 1'b0;
      rdata_o <= '0;
    end else if (en_i) begin
      drv_o <= s2_vld_i && s2_rd_i;
      if (s2_vld_i && s2_rd_i) rdata_o <= merged;
    end
  end

  AST_DRV_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_o) |-> $past(en_i && s2_vld_i && s2_rd_i)); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s2_vld_i && !s2_rd_i) |=> !drv_o); // R3
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned ADDR_W  = ZBT_ADDR_W,
  parameter int unsigned BYTES   = ZBT_BYTES,
  parameter int unsigned BYTE_W  = ZBT_BYTE_W,
  parameter int unsigned BURST_W = ZBT_BURST_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_n_i,
  input  logic                    adv_ld_n_i,
  input  logic                    rw_i,
  input  logic                    cs1_n_i,
  input  logic                    cs2_i,
  input  logic                    cs3_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES-1:0]        bw_n_i,
  input  logic                    burst_ilv_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    rdata_en_o
);
  localparam int unsigned WORD_W = BYTES * BYTE_W;
  localparam int unsigned S2_W   = 2 + ADDR_W + BYTES;

  logic              en, sel, drv;
  logic              s1_vld, s1_rd, s2_vld, s2_rd;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [BYTES-1:0]  s1_be, s2_be;
  logic [WORD_W-1:0] ram_q;

  assign en  = !cke_n_i;
  assign sel = !cs1_n_i && cs2_i && !cs3_n_i;

  zbt_cmd #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BURST_W(BURST_W)) u_cmd (
    .clk_i, .rst_ni, .en_i(en), .ld_n_i(adv_ld_n_i), .rd_i(rw_i), .sel_i(sel),
    .addr_i, .bw_n_i, .ilv_i(burst_ilv_i),
    .s1_vld_o(s1_vld), .s1_rd_o(s1_rd), .s1_addr_o(s1_addr), .s1_be_o(s1_be)
  );

  zbt_stage #(.W(S2_W)) u_s2 (
    .clk_i, .rst_ni, .en_i(en),
    .d_i({s1_vld, s1_rd, s1_addr, s1_be}),
    .q_o({s2_vld, s2_rd, s2_addr, s2_be})
  );

  zbt_ram #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_ram (
    .clk_i, .en_i(en),
    .we_be_i(s2_be & {BYTES{s2_vld && !s2_rd}}), .waddr_i(s2_addr), .wdata_i,
    .re_i(s1_vld && s1_rd), .raddr_i(s1_addr), .rdata_o(ram_q)
  );

  zbt_rd_path #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_rd (
    .clk_i, .rst_ni, .en_i(en),
    .s1_vld_i(s1_vld), .s1_rd_i(s1_rd), .s1_addr_i(s1_addr),
    .s2_vld_i(s2_vld), .s2_rd_i(s2_rd), .s2_addr_i(s2_addr), .s2_be_i(s2_be),
    .wdata_i, .ram_q_i(ram_q), .rdata_o, .drv_o(drv)
  );

  assign rdata_en_o = drv && !oe_n_i;

  AST_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_n_i |=> ($stable(rdata_o) && $stable(drv))); // R6
  AST_DESEL_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_n_i && !adv_ld_n_i && !sel) ##1 !cke_n_i ##1 !cke_n_i |=> !drv); // R7
endmodule

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
  localparam int AW = 10;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int WW = NB * BW;

  logic          clk = 0, rst_n = 0;
  logic          cke_n = 0, adv_n = 0, rw = 0, cs1_n = 1, cs2 = 0, cs3_n = 1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] bw_n = '1;
  logic          ilv = 0, oe_n = 0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          rdata_en;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    live = 0;

  always #5 clk = ~clk;

  zbt_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_n_i(cke_n), .adv_ld_n_i(adv_n), .rw_i(rw),
    .cs1_n_i(cs1_n), .cs2_i(cs2), .cs3_n_i(cs3_n), .addr_i(addr), .bw_n_i(bw_n),
    .burst_ilv_i(ilv), .wdata_i(wdata), .oe_n_i(oe_n), .rdata_o(rdata), .rdata_en_o(rdata_en)
  );

  // behavioural reference model
  typedef struct { bit vld; bit rd; int a; bit [NB-1:0] be; } op_t;
  op_t           pq[$];
  logic [WW-1:0] mm [int];
  bit            m_act, m_rd, exp_drv;
  int            m_base, m_cnt;
  logic [WW-1:0] exp_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq.delete();
      pq.push_back('{0, 0, 0, 0});
      pq.push_back('{0, 0, 0, 0});
      m_act = 0; exp_drv = 0;
    end else if (!cke_n) begin
      op_t o, p;
      bit  s;
      s = !cs1_n && cs2 && !cs3_n;
      o = '{0, 0, 0, 0};
      if (!adv_n) begin
        m_act = s;
        if (s) begin
          m_base = int'(addr); m_cnt = 0; m_rd = rw;
          o = '{1, rw, int'(addr), rw ? 4'b0 : ~bw_n};
        end
      end else if (m_act) begin
        int lo;
        m_cnt = (m_cnt + 1) % 4;
        lo = ilv ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
        o = '{1, m_rd, (m_base / 4) * 4 + lo, m_rd ? 4'b0 : ~bw_n};
      end
      pq.push_back(o);
      p = pq.pop_front();
      if (p.vld && !p.rd) begin
        logic [WW-1:0] w;
        w = mm.exists(p.a) ? mm[p.a] : '0;
        for (int b = 0; b < NB; b++) if (p.be[b]) w[b*BW +: BW] = wdata[b*BW +: BW];
        mm[p.a] = w;
      end
      exp_drv = p.vld && p.rd;
      if (exp_drv) exp_d = mm.exists(p.a) ? mm[p.a] : '0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk(rdata_en == (exp_drv && !oe_n), cur_req, WW'(rdata_en), WW'(exp_drv && !oe_n));
      if (exp_drv && !oe_n) chk(rdata == exp_d, cur_req, rdata, exp_d);
    end
  end

  // one cycle of stimulus: 0 selected, 1 cs1 high, 2 cs2 low, 3 cs3 high
  task automatic cyc(input bit an, input bit r, input int a, input logic [NB-1:0] b,
                     input bit ck = 0, input int ds = 0);
    @(negedge clk); #1;
    adv_n = an; rw = r; addr = AW'(a); bw_n = b; cke_n = ck;
    cs1_n = (ds == 1); cs2 = (ds != 2); cs3_n = (ds == 3);
    wdata = {$urandom, $urandom};
  endtask

  task automatic nop(input int n = 1);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, '1, 0, 1);
  endtask

  logic [WW-1:0] held;

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata_en == 0, "R1", WW'(rdata_en), '0);
    rst_n = 1; live = 1;
    cur_req = "R12"; cyc(1, 1, 0, '1); cyc(1, 0, 5, '0); nop(3);
    chk(rdata_en == 0, "R1", WW'(rdata_en), '0);
    cur_req = "R3";
    for (int i = 0; i < 64; i++) cyc(0, 0, i, '0);
    nop(2);
    cur_req = "R2";
    for (int i = 0; i < 16; i++) cyc(0, 1, (i * 7) % 64, '1);
    nop(2);
    cur_req = "R5";
    for (int i = 0; i < 24; i++) begin
      cyc(0, 0, i % 8, 4'(i));
      cyc(0, 1, i % 8, '1);
    end
    for (int i = 0; i < 8; i++) cyc(0, i % 2 == 1, 20, 4'(~(1 << (i % 4))));
    nop(2);
    cur_req = "R4";
    for (int i = 0; i < 8; i++) cyc(0, 1, 30 + i, 4'(i));
    nop(2);
    cur_req = "R6";
    cyc(0, 1, 3, '1); nop(2);
    cyc(0, 1, 9, '1, 1);
    #2 held = rdata;
    chk(rdata_en == 1, "R6", WW'(rdata_en), WW'(1));
    cyc(0, 0, 3, '0, 1); #2 chk(rdata == held && rdata_en, "R6", rdata, held);
    cyc(1, 0, 3, '0, 1); #2 chk(rdata == held && rdata_en, "R6", rdata, held);
    nop(3);
    cur_req = "R7";
    for (int d = 1; d <= 3; d++) begin
      cyc(0, 1, 11, '1); cyc(0, 1, 12, '1, 0, d); cyc(0, 1, 13, '1); nop(3);
    end
    cur_req = "R8"; ilv = 0;
    cyc(0, 0, 41, '0); cyc(1, 1, 0, 4'b1010); cyc(1, 1, 63, '0); cyc(1, 1, 2, 4'b0110); cyc(1, 0, 7, '0);
    cyc(0, 1, 42, '1); for (int i = 0; i < 5; i++) cyc(1, 0, i, '0);
    nop(3);
    cur_req = "R9"; ilv = 1;
    cyc(0, 0, 50, '0); for (int i = 0; i < 3; i++) cyc(1, 1, i, 4'(i));
    cyc(0, 1, 51, '1); for (int i = 0; i < 4; i++) cyc(1, 0, 60, '0);
    nop(3); ilv = 0;
    cur_req = "R10";
    cyc(0, 1, 44, '1); cyc(1, 1, 0, '1); cyc(0, 1, 0, '1, 0, 2);
    for (int i = 0; i < 4; i++) cyc(1, 0, 44, '0);
    nop(3);
    cur_req = "R11";
    for (int i = 0; i < 6; i++) begin
      cyc(0, 1, i, '1);
      #1 oe_n = (i % 2 == 0);
    end
    nop(3); oe_n = 0;
    for (int ph = 0; ph < 2; ph++) begin
      ilv = ph[0];
      cur_req = ph == 0 ? "R8" : "R9";
      for (int i = 0; i < 1500; i++) begin
        cyc($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 63),
            4'($urandom), $urandom_range(0, 7) == 0,
            $urandom_range(0, 7) == 0 ? $urandom_range(1, 3) : 0);
        oe_n = ($urandom_range(0, 9) == 0);
      end
      nop(3); oe_n = 0;
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog act timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule